// File: doc/BRIEF.md
# Wake-Up Event Status Controller

This block gathers wake-up requests from several power-management sources into one status register. The sources are two network receive paths that report a detected wake packet, one timer compare match, and two external interrupt pins. Each source has a sticky status bit. The bit latches only while the mask bit for that source is set. Software clears a status bit by writing a one to it. When the bit is cleared, the request is considered handled.

A latched source whose mask bit is set drives one of two level outputs. These are the processor interrupt and an external power-management-event line, and a routing bit in the control register chooses between them. A separate summary bit collects three conditions. The first is a wake event while routing points at the processor. The second is a difference between the current and the requested power state while state tracking is enabled. The third is a new request on the system bus while that bus is in low-power mode. The summary bit raises the processor interrupt only when its own enable bit is set.

Packet detection, timer counting and power-state sequencing are done outside this block. Their results arrive as pulses or levels. Software reaches the registers through a small single-cycle register port whose read data is combinational.

Top module: `wkev_ctl`

## Requirements
- R1: After synchronous reset, the status, mask and control registers all read 0, and `core_irq` and `pme_out` are low.
- R2: The status register is at address 0. A one-cycle pulse on `net_magic[0]`, `net_magic[1]` or `tmr_match` sets status bit 0, 1 or 2 at that clock edge. A high level on `ext_pin[0]` or `ext_pin[1]` sets status bit 3 or 4 on the third rising edge after the pin rises, because the pin passes through a two-stage synchronizer. Once set, a bit stays set after its source goes away.
- R3: A source event does not set its status bit while that source's bit in the mask register (address 1, bits 4..0) is 0.
- R4: A bus write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: If a source event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R6: Control register (address 2) bit 0 selects routing. When it is 0, any status bit 4..0 that is set with its mask bit set drives `core_irq` high. When it is 1, such a bit drives `pme_out` high instead. Both outputs are levels that stay high while any such bit remains set.
- R7: Status bit 5 (the summary bit) is set by a source event whose mask bit is set, but only while control bit 0 is 0.
- R8: Status bit 5 is set while control bit 1 (state tracking) is 1 and `pwr_cur_state` differs from `pwr_next_state`. It is not set by a mismatch while control bit 1 is 0.
- R9: Status bit 5 is set by a rising edge of `sys_bus_req` while `sys_bus_lowpwr` is high. A request that stays high sets the bit only once, and a request made while `sys_bus_lowpwr` is low has no effect.
- R10: Status bit 5 drives `core_irq` only while mask bit 5 is 1. Writing 1 to status bit 5 clears it.
- R11: The mask register and control bits 1..0 read back the values last written. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_magic | input | 2 | Wake-packet detected pulses, one per network path |
| tmr_match | input | 1 | Timer compare-match pulse |
| ext_pin | input | 2 | Asynchronous external interrupt pins, active high |
| pwr_cur_state | input | 2 | Current power state |
| pwr_next_state | input | 2 | Requested next power state |
| sys_bus_req | input | 1 | System bus request level |
| sys_bus_lowpwr | input | 1 | System bus is in low-power mode |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| core_irq | output | 1 | Processor interrupt request level |
| pme_out | output | 1 | External power-management-event level |

## Verification
The assertions check the following on every cycle:
- the mask gate on each status bit;
- write-one-to-clear without a competing event, and the event winning over a clear;
- the summary bit following a state mismatch or a low-power bus request;
- the event line never being high with processor routing selected;
- the interrupt staying low while nothing enabled can drive it;
- register write-back.

Only the bench scenarios show the following:
- the synchronizer delay of the pins;
- the mapping of each source to its bit position;
- that a held bus request does not set the summary bit again;
- that writing zeros leaves the status unchanged.

The bench also checks the level behaviour of both outputs as status bits are cleared.

// File: rtl/wkev_pkg.sv
package wkev_pkg;

    localparam int NET_CNT     = 2;
    localparam int TMR_CNT     = 1;
    localparam int PIN_CNT     = 2;
    localparam int SRC_CNT     = NET_CNT + TMR_CNT + PIN_CNT;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int STATE_W     = 2;
    localparam int SYNC_STAGES = 2;

    // Bit positions of the sources inside the status and mask registers
    localparam int NET_LSB = 0;
    localparam int TMR_LSB = NET_LSB + NET_CNT;
    localparam int PIN_LSB = TMR_LSB + TMR_CNT;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_CTRL   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               summary;
        logic [SRC_CNT-1:0] src;
    } stat_t;

    typedef struct packed {
        logic               sum_ie;
        logic [SRC_CNT-1:0] src;
    } mask_t;

    typedef struct packed {
        logic use_state;
        logic route_pme;
    } ctrl_t;

    localparam int STAT_W = $bits(stat_t);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic              sel;
        logic              wr;
        reg_sel_e          addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] widen_stat(input stat_t v);
        return DATA_W'(v);
    endfunction

    function automatic logic [DATA_W-1:0] widen_ctrl(input ctrl_t v);
        return DATA_W'(v);
    endfunction

endpackage

// File: rtl/wkev_pin_sync.sv
module wkev_pin_sync
    import wkev_pkg::*;
#(
    parameter int   LANES       = PIN_CNT,
    parameter int   STAGES      = SYNC_STAGES,
    parameter logic ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] pin_raw,
    output logic [LANES-1:0] pin_active
);

    localparam logic IDLE_LVL = ~ACTIVE_HIGH;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{IDLE_LVL}};
            end else begin
                chain <= {chain[STAGES-2:0], pin_raw[g]};
            end
        end

        assign pin_active[g] = (chain[STAGES-1] == ACTIVE_HIGH);
    end

endmodule

// File: rtl/wkev_regs.sv
module wkev_regs
    import wkev_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  stat_t             stat_q,
    output mask_t             mask_q,
    output ctrl_t             ctrl_q,
    output stat_t             clr_vec,
    output logic [DATA_W-1:0] rdata
);

    logic wr_stat, wr_mask, wr_ctrl;
    logic unused_wbits;

    assign wr_stat = cmd.sel && cmd.wr && (cmd.addr == REG_STATUS);
    assign wr_mask = cmd.sel && cmd.wr && (cmd.addr == REG_MASK);
    assign wr_ctrl = cmd.sel && cmd.wr && (cmd.addr == REG_CTRL);

    assign unused_wbits = ^cmd.wdata[DATA_W-1:STAT_W];

    always_comb begin
        clr_vec = '0;
        if (wr_stat) begin
            clr_vec = stat_t'(cmd.wdata[STAT_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_mask) mask_q <= mask_t'(cmd.wdata[STAT_W-1:0]);
            if (wr_ctrl) ctrl_q <= ctrl_t'(cmd.wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        unique case (cmd.addr)
            REG_STATUS: rdata = widen_stat(stat_q);
            REG_MASK:   rdata = DATA_W'(mask_q);
            REG_CTRL:   rdata = widen_ctrl(ctrl_q);
            default:    rdata = '0;
        endcase
    end

    assert_mask_write_R11: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == mask_t'($past(cmd.wdata[STAT_W-1:0]))));

    assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q == ctrl_t'($past(cmd.wdata[CTRL_W-1:0]))));

endmodule

// File: rtl/wkev_status.sv
module wkev_status
    import wkev_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SRC_CNT-1:0] evt,
    input  mask_t              mask_q,
    input  ctrl_t              ctrl_q,
    input  stat_t              clr_vec,
    input  logic [STATE_W-1:0] cur_state,
    input  logic [STATE_W-1:0] next_state,
    input  logic               bus_req,
    input  logic               bus_lowpwr,
    output stat_t              stat_q
);

    logic [SRC_CNT-1:0] hit;
    logic               wake_any;
    logic               state_diff;
    logic               bus_new;
    logic               sum_set;
    logic               req_q;
    stat_t              stat_d;

    assign hit        = evt & mask_q.src;
    assign wake_any   = |hit;
    assign state_diff = ctrl_q.use_state && (cur_state != next_state);
    assign bus_new    = bus_req && !req_q && bus_lowpwr;
    assign sum_set    = (wake_any && !ctrl_q.route_pme) || state_diff || bus_new;

    // Setting has priority over a clear written in the same cycle
    always_comb begin
        stat_d.src     = (stat_q.src & ~clr_vec.src) | hit;
        stat_d.summary = (stat_q.summary & ~clr_vec.summary) | sum_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            req_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            req_q  <= bus_req;
        end
    end

    for (genvar g = 0; g < SRC_CNT; g++) begin : g_chk
        assert_mask_gate_R3: assert property (@(posedge clk) disable iff (rst)
            (!mask_q.src[g] && !stat_q.src[g]) |=> !stat_q.src[g]);

        assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
            (clr_vec.src[g] && !evt[g]) |=> !stat_q.src[g]);

        assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
            (evt[g] && mask_q.src[g]) |=> stat_q.src[g]);
    end

    assert_state_diff_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.use_state && (cur_state != next_state)) |=> stat_q.summary);

    assert_bus_wake_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !req_q && bus_lowpwr) |=> stat_q.summary);

    assert_sum_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_vec.summary && !wake_any && !state_diff && !bus_req) |=> !stat_q.summary);

endmodule

// File: rtl/wkev_route.sv
module wkev_route
    import wkev_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t stat_q,
    input  mask_t mask_q,
    input  ctrl_t ctrl_q,
    output logic  core_irq,
    output logic  pme_out
);

    logic wake_pend;
    logic sum_pend;

    assign wake_pend = |(stat_q.src & mask_q.src);
    assign sum_pend  = stat_q.summary && mask_q.sum_ie;
    assign core_irq  = (wake_pend && !ctrl_q.route_pme) || sum_pend;
    assign pme_out   = wake_pend && ctrl_q.route_pme;

    assert_pme_route_R6: assert property (@(posedge clk) disable iff (rst)
        pme_out |-> ctrl_q.route_pme);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!mask_q.sum_ie && (ctrl_q.route_pme || (stat_q.src == '0))) |-> !core_irq);

endmodule

// File: rtl/wkev_ctl.sv
module wkev_ctl
    import wkev_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NET_CNT-1:0] net_magic,
    input  logic               tmr_match,
    input  logic [PIN_CNT-1:0] ext_pin,
    input  logic [STATE_W-1:0] pwr_cur_state,
    input  logic [STATE_W-1:0] pwr_next_state,
    input  logic               sys_bus_req,
    input  logic               sys_bus_lowpwr,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               core_irq,
    output logic               pme_out
);

    logic [PIN_CNT-1:0] pin_active;
    logic [SRC_CNT-1:0] evt;
    bus_cmd_t           cmd;
    stat_t              stat_q;
    stat_t              clr_vec;
    mask_t              mask_q;
    ctrl_t              ctrl_q;

    assign cmd.sel   = bus_sel;
    assign cmd.wr    = bus_wr;
    assign cmd.addr  = reg_sel_e'(bus_addr);
    assign cmd.wdata = bus_wdata;

    assign evt[NET_LSB +: NET_CNT] = net_magic;
    assign evt[TMR_LSB]            = tmr_match;
    assign evt[PIN_LSB +: PIN_CNT] = pin_active;

    wkev_pin_sync #(
        .LANES      (PIN_CNT),
        .STAGES     (SYNC_STAGES),
        .ACTIVE_HIGH(1'b1)
    ) pin_sync_i (
        .clk       (clk),
        .rst       (rst),
        .pin_raw   (ext_pin),
        .pin_active(pin_active)
    );

    wkev_regs regs_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .stat_q (stat_q),
        .mask_q (mask_q),
        .ctrl_q (ctrl_q),
        .clr_vec(clr_vec),
        .rdata  (bus_rdata)
    );

    wkev_status status_i (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .mask_q    (mask_q),
        .ctrl_q    (ctrl_q),
        .clr_vec   (clr_vec),
        .cur_state (pwr_cur_state),
        .next_state(pwr_next_state),
        .bus_req   (sys_bus_req),
        .bus_lowpwr(sys_bus_lowpwr),
        .stat_q    (stat_q)
    );

    wkev_route route_i (
        .clk     (clk),
        .rst     (rst),
        .stat_q  (stat_q),
        .mask_q  (mask_q),
        .ctrl_q  (ctrl_q),
        .core_irq(core_irq),
        .pme_out (pme_out)
    );

endmodule

// File: tb/wkev_ctl_tb_top.sv
module wkev_ctl_tb_top;
    import wkev_pkg::*;

    localparam int WATCHDOG_CYC = 20000;
    localparam int OUTS = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst;
    logic [NET_CNT-1:0] net_magic;
    logic               tmr_match;
    logic [PIN_CNT-1:0] ext_pin;
    logic [STATE_W-1:0] pwr_cur_state, pwr_next_state;
    logic               sys_bus_req, sys_bus_lowpwr;
    logic               bus_sel, bus_wr;
    logic [ADDR_W-1:0]  bus_addr;
    logic [DATA_W-1:0]  bus_wdata, bus_rdata;
    logic               core_irq, pme_out;

    wkev_ctl dut_i (
        .clk(clk), .rst(rst), .net_magic(net_magic), .tmr_match(tmr_match),
        .ext_pin(ext_pin), .pwr_cur_state(pwr_cur_state),
        .pwr_next_state(pwr_next_state), .sys_bus_req(sys_bus_req),
        .sys_bus_lowpwr(sys_bus_lowpwr), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_irq(core_irq), .pme_out(pme_out)
    );

    typedef struct {
        string      req;
        int         what;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // Monitor: pops expected items and compares with the design's outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = (it.what == OUTS) ? {6'b0, pme_out, core_irq} : bus_rdata;
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Driver side of the scoreboard; uses up one clock cycle
    task automatic expect_item(input string req, input int what, input logic [7:0] e);
        if (what != OUTS) bus_addr = what[ADDR_W-1:0];
        #1;
        sb_q.push_back('{req, what, e});
        ->chk_ev;
        #1;
        @(negedge clk);
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        step(1);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse_net(input int i);
        net_magic[i] = 1'b1;
        step(1);
        net_magic[i] = 1'b0;
    endtask

    initial begin
        #(WATCHDOG_CYC * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; net_magic = '0; tmr_match = 1'b0; ext_pin = '0;
        pwr_cur_state = '0; pwr_next_state = '0; sys_bus_req = 1'b0;
        sys_bus_lowpwr = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        step(3);
        rst = 1'b0;

        // R1 reset state
        expect_item("R1 status", 0, 8'h00);
        expect_item("R1 mask", 1, 8'h00);
        expect_item("R1 ctrl", 2, 8'h00);
        expect_item("R1 outputs", OUTS, 8'h00);

        // R3 masked sources are ignored
        pulse_net(0);
        ext_pin[0] = 1'b1;
        step(5);
        ext_pin[0] = 1'b0;
        step(3);
        expect_item("R3 masked status", 0, 8'h00);
        expect_item("R3 masked outputs", OUTS, 8'h00);

        // R2/R7/R6 net0 with routing to the processor
        bus_write(1, 8'h1F);
        pulse_net(0);
        expect_item("R2 R7 net0 plus summary", 0, 8'h21);
        expect_item("R6 core irq level", OUTS, 8'h01);

        // R4 write-zero keeps, write-one clears
        bus_write(0, 8'h00);
        expect_item("R4 zero write", 0, 8'h21);
        bus_write(0, 8'h01);
        expect_item("R4 clear bit0", 0, 8'h20);
        expect_item("R10 summary masked", OUTS, 8'h00);
        bus_write(0, 8'h20);
        expect_item("R10 summary cleared", 0, 8'h00);

        // R6/R7 timer routed to the event line
        bus_write(2, 8'h01);
        tmr_match = 1'b1;
        step(1);
        tmr_match = 1'b0;
        expect_item("R2 R7 timer no summary", 0, 8'h04);
        expect_item("R6 pme level", OUTS, 8'h02);
        bus_write(0, 8'h04);
        expect_item("R6 pme drops", OUTS, 8'h00);

        // R2 net1
        pulse_net(1);
        expect_item("R2 net1", 0, 8'h02);
        bus_write(0, 8'h02);

        // R2 pin1 synchronizer delay and stickiness
        ext_pin[1] = 1'b1;
        step(1);
        expect_item("R2 pin1 not before third edge", 0, 8'h00);
        step(1);
        expect_item("R2 pin1 set", 0, 8'h10);
        ext_pin[1] = 1'b0;
        step(3);
        expect_item("R2 pin1 sticky", 0, 8'h10);
        bus_write(0, 8'h10);
        ext_pin[0] = 1'b1;
        step(3);
        ext_pin[0] = 1'b0;
        expect_item("R2 pin0", 0, 8'h08);
        step(3);
        bus_write(0, 8'h08);
        expect_item("R4 pins cleared", 0, 8'h00);

        // R5 event beats clear in the same cycle
        pulse_net(0);
        net_magic[0] = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h01;
        step(1);
        net_magic[0] = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        expect_item("R5 event wins", 0, 8'h01);
        bus_write(0, 8'h01);

        // R8 state mismatch
        bus_write(2, 8'h00);
        pwr_cur_state = 2'd1; pwr_next_state = 2'd2;
        step(3);
        expect_item("R8 tracking off", 0, 8'h00);
        bus_write(2, 8'h02);
        step(1);
        expect_item("R8 mismatch summary", 0, 8'h20);
        expect_item("R10 no irq without enable", OUTS, 8'h00);
        bus_write(1, 8'h3F);
        expect_item("R10 irq with enable", OUTS, 8'h01);
        pwr_cur_state = 2'd2;
        step(1);
        bus_write(0, 8'h20);
        expect_item("R10 summary w1c", 0, 8'h00);
        expect_item("R10 irq drops", OUTS, 8'h00);
        bus_write(2, 8'h00);

        // R9 bus request in low power
        sys_bus_req = 1'b1;
        step(2);
        expect_item("R9 not low power", 0, 8'h00);
        sys_bus_req = 1'b0;
        step(1);
        sys_bus_lowpwr = 1'b1;
        sys_bus_req = 1'b1;
        step(1);
        expect_item("R9 low power request", 0, 8'h20);
        bus_write(0, 8'h20);
        step(2);
        expect_item("R9 held request once", 0, 8'h00);
        sys_bus_req = 1'b0;
        sys_bus_lowpwr = 1'b0;

        // R11 readback
        expect_item("R11 mask", 1, 8'h3F);
        bus_write(2, 8'h03);
        expect_item("R11 ctrl", 2, 8'h03);
        expect_item("R11 spare", 3, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule